// File: doc/BRIEF.md
# Shared Data Bus Loan Controller

This block sits on the controller side of a 64-bit data bus that an external device may borrow to post a DMA transfer request. The device raises a release-request input. When the bus is free, the controller answers with a single-cycle bus-available pulse. It then stops driving the data pins for a short turnaround window that is centred on the release cycle, and it captures the request word the device places on the bus in that centre cycle.

A separate transfer-request strobe from the device is decoded into one of three kinds. The first is a normal request, which takes its word and channel from the bus in the capture slot. The second is a repeat of the most recently requested channel, which needs no bus. The third is a direct request to a fixed channel, raised when release request and strobe arrive together. Each decoded request leaves the block as a one-cycle valid pulse with its channel, kind and word, and a downstream DMA engine consumes it.

Top module: `bus_loan_ctrl`

## Requirements
- R1: After reset the controller drives the data bus (`data_oe_o` = 1), `bus_avail_o` and `req_valid_o` are 0, and the stored last channel is 0, so a repeat request issued before any other request reports channel 0.
- R2: A release request sampled high, with the strobe low and no turnaround in progress, produces `bus_avail_o` high for exactly one cycle, in the cycle after the sampling edge.
- R3: With the default window length of 3, `data_oe_o` is low in exactly the three cycles that follow a bus-available cycle (A+1, A+2, A+3), and high at all other times.
- R4: A release request is ignored from the bus-available cycle through the last cycle of the turnaround window. A request held high continuously therefore yields bus-available pulses five cycles apart.
- R5: A strobe in the capture slot (two cycles after bus-available) yields, one cycle later, a valid pulse with kind 2'b00 (normal), channel equal to bits [1:0] of the bus word, and the full word. This holds even when the release request is also high in that cycle.
- R6: A strobe outside the capture slot with the release request low yields, one cycle later, a valid pulse with kind 2'b01 (repeat) and the stored last channel.
- R7: A strobe outside the capture slot with the release request high in the same cycle yields, one cycle later, a valid pulse with kind 2'b10 (direct) and channel 2. It raises no bus-available pulse.
- R8: The stored last channel takes the channel of each normal request and the value 2 on each direct request. A repeat request leaves it unchanged.
- R9: `req_valid_o` is high in the cycle after each strobe cycle and low in the cycle after each cycle without a strobe.
- R10: Bus data outside the capture slot is ignored: repeat and direct requests report a word of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rel_req_i | input | 1 | Bus release request from the external device |
| xfer_req_i | input | 1 | Transfer-request strobe from the external device |
| data_i | input | DATA_W (64) | Data bus as seen by the controller |
| bus_avail_o | output | 1 | Single-cycle pulse: bus will be released two cycles later |
| data_oe_o | output | 1 | Controller data pin output enable |
| req_valid_o | output | 1 | Decoded request valid, one cycle |
| req_chan_o | output | CHAN_W (2) | Channel of the decoded request |
| req_kind_o | output | 2 | 00 normal, 01 repeat, 10 direct |
| req_word_o | output | DATA_W (64) | Captured request word, 0 unless normal |

## Verification
A turnaround history that is wrong by one position shows at the ports within four cycles of the bus-available pulse. It appears as an output-enable gap that is shifted or has the wrong length, or as a strobe in the capture slot decoded as a repeat. A corrupted last-channel register stays hidden until the next repeat strobe, so the sweep issues repeats right after each normal and direct request. A wrong busy term shows as a bus-available pulse inside the window, or as a missing pulse on the first free cycle, when the release request is held high.

// File: rtl/bl_pkg.sv
package bl_pkg;
   typedef enum logic [1:0] {
      KIND_NORMAL = 2'b00,
      KIND_REPEAT = 2'b01,
      KIND_DIRECT = 2'b10
   } bl_kind_e;
endpackage

// File: rtl/bl_turnaround.sv
// Bus-available pulse and the history chain behind it. The turnaround
// window spans GAP_LEN cycles after the pulse, centred on the release cycle.
module bl_turnaround #(
   parameter int unsigned GAP_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   output logic avail_o,
   output logic capture_o,
   output logic drive_o,
   output logic busy_o
);
   localparam int unsigned CENTRE = (GAP_LEN + 1) / 2;

   if (GAP_LEN < 3 || (GAP_LEN % 2) == 0) begin : g_bad_gap
      $error("bl_turnaround: GAP_LEN must be odd and at least 3");
   end

   logic               avail_q;
   logic [GAP_LEN:1]   hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) avail_q <= 1'b0;
      else        avail_q <= accept_i;
   end

   for (genvar i = 1; i <= GAP_LEN; i++) begin : g_hist
      if (i == 1) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) hist_q[i] <= 1'b0;
            else        hist_q[i] <= avail_q;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) hist_q[i] <= 1'b0;
            else        hist_q[i] <= hist_q[i-1];
         end
      end
   end

   assign avail_o   = avail_q;
   assign capture_o = hist_q[CENTRE];
   assign drive_o   = ~(|hist_q);
   assign busy_o    = avail_q | (|hist_q);
endmodule

// File: rtl/bl_req_decode.sv
// Decodes the transfer-request strobe into normal, repeat or direct, and
// keeps the last requested channel for the repeat case.
module bl_req_decode
   import bl_pkg::*;
#(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned CHAN_W      = 2,
   parameter int unsigned DIRECT_CHAN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic              rel_i,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              valid_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic [1:0]        kind_o,
   output logic [DATA_W-1:0] word_o
);
   localparam logic [CHAN_W-1:0] DIRECT_ID = CHAN_W'(DIRECT_CHAN);

   if (CHAN_W < 1 || DATA_W < CHAN_W) begin : g_bad_width
      $error("bl_req_decode: channel field must fit in the data word");
   end
   if (DIRECT_CHAN >= (1 << CHAN_W)) begin : g_bad_direct
      $error("bl_req_decode: DIRECT_CHAN out of channel range");
   end

   logic [CHAN_W-1:0] last_q;
   logic [CHAN_W-1:0] nxt_chan;
   bl_kind_e          nxt_kind;
   logic [DATA_W-1:0] nxt_word;
   logic              upd_last;

   always_comb begin
      nxt_word = '0;
      upd_last = 1'b0;
      if (capture_i) begin
         nxt_kind = KIND_NORMAL;
         nxt_chan = word_i[CHAN_W-1:0];
         nxt_word = word_i;
         upd_last = strobe_i;
      end else if (rel_i) begin
         nxt_kind = KIND_DIRECT;
         nxt_chan = DIRECT_ID;
         upd_last = strobe_i;
      end else begin
         nxt_kind = KIND_REPEAT;
         nxt_chan = last_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q  <= '0;
         valid_o <= 1'b0;
         chan_o  <= '0;
         kind_o  <= KIND_NORMAL;
         word_o  <= '0;
      end else begin
         valid_o <= strobe_i;
         if (upd_last) last_q <= nxt_chan;
         if (strobe_i) begin
            chan_o <= nxt_chan;
            kind_o <= nxt_kind;
            word_o <= nxt_word;
         end else begin
            chan_o <= '0;
            kind_o <= KIND_NORMAL;
            word_o <= '0;
         end
      end
   end
endmodule

// File: rtl/bus_loan_ctrl.sv
module bus_loan_ctrl #(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned CHAN_W      = 2,
   parameter int unsigned DIRECT_CHAN = 2,
   parameter int unsigned GAP_LEN     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rel_req_i,
   input  logic              xfer_req_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              bus_avail_o,
   output logic              data_oe_o,
   output logic              req_valid_o,
   output logic [CHAN_W-1:0] req_chan_o,
   output logic [1:0]        req_kind_o,
   output logic [DATA_W-1:0] req_word_o
);
   logic busy;
   logic capture;
   logic accept;

   // A release request together with the strobe is a direct request,
   // not a bus loan.
   assign accept = rel_req_i & ~xfer_req_i & ~busy;

   bl_turnaround #(.GAP_LEN(GAP_LEN)) turn_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .avail_o   (bus_avail_o),
      .capture_o (capture),
      .drive_o   (data_oe_o),
      .busy_o    (busy)
   );

   bl_req_decode #(
      .DATA_W      (DATA_W),
      .CHAN_W      (CHAN_W),
      .DIRECT_CHAN (DIRECT_CHAN)
   ) dec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_i  (xfer_req_i),
      .rel_i     (rel_req_i),
      .capture_i (capture),
      .word_i    (data_i),
      .valid_o   (req_valid_o),
      .chan_o    (req_chan_o),
      .kind_o    (req_kind_o),
      .word_o    (req_word_o)
   );
endmodule

// File: rtl/bus_loan_ctrl_chk.sv
module bus_loan_ctrl_chk #(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned CHAN_W      = 2,
   parameter int unsigned DIRECT_CHAN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rel_req_i,
   input logic              xfer_req_i,
   input logic              bus_avail_o,
   input logic              data_oe_o,
   input logic              req_valid_o,
   input logic [CHAN_W-1:0] req_chan_o,
   input logic [1:0]        req_kind_o,
   input logic [DATA_W-1:0] req_word_o
);
   p_avail_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_avail_o |=> !bus_avail_o);

   p_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_avail_o |=> !data_oe_o ##1 !data_oe_o ##1 !data_oe_o);

   p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_avail_o |=> !bus_avail_o ##1 !bus_avail_o ##1 !bus_avail_o ##1 !bus_avail_o);

   p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req_i && xfer_req_i && !$past(bus_avail_o, 2))
      |=> (req_valid_o && req_kind_o == 2'b10 && req_chan_o == CHAN_W'(DIRECT_CHAN)
           && !bus_avail_o));

   p_strobe_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_i |=> req_valid_o);

   p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req_i |=> !req_valid_o);

   p_repeat_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_kind_o != 2'b00) |-> req_word_o == '0);
endmodule

bind bus_loan_ctrl bus_loan_ctrl_chk #(
   .DATA_W      (DATA_W),
   .CHAN_W      (CHAN_W),
   .DIRECT_CHAN (DIRECT_CHAN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rel_req_i   (rel_req_i),
   .xfer_req_i  (xfer_req_i),
   .bus_avail_o (bus_avail_o),
   .data_oe_o   (data_oe_o),
   .req_valid_o (req_valid_o),
   .req_chan_o  (req_chan_o),
   .req_kind_o  (req_kind_o),
   .req_word_o  (req_word_o)
);

// File: tb/bus_loan_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_loan_ctrl_tb_top;
   localparam int MAX_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rel_req_i = 1'b0;
   logic        xfer_req_i = 1'b0;
   logic [63:0] data_i = '0;
   logic        bus_avail_o, data_oe_o, req_valid_o;
   logic [1:0]  req_chan_o, req_kind_o;
   logic [63:0] req_word_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bus_loan_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .rel_req_i(rel_req_i), .xfer_req_i(xfer_req_i),
      .data_i(data_i), .bus_avail_o(bus_avail_o), .data_oe_o(data_oe_o),
      .req_valid_o(req_valid_o), .req_chan_o(req_chan_o), .req_kind_o(req_kind_o),
      .req_word_o(req_word_o)
   );

   // Reference state built from the requirements
   logic [3:0]  av_h = '0;       // av_h[i]: bus-available expected i cycles ago
   logic [1:0]  m_last = '0;
   logic        e_avail = 0, e_oe = 1, e_valid = 0;
   logic [1:0]  e_chan = 0, e_kind = 0;
   logic [63:0] e_word = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input logic rel, input logic xfer, input logic [63:0] data);
      logic nav, cap, busy;
      @(negedge clk);
      chk(bus_avail_o == e_avail, "R2 R4 bus_avail", 64'(bus_avail_o), 64'(e_avail));
      chk(data_oe_o == e_oe, "R3 data_oe", 64'(data_oe_o), 64'(e_oe));
      chk(req_valid_o == e_valid, "R9 req_valid", 64'(req_valid_o), 64'(e_valid));
      if (e_valid) begin
         case (e_kind)
            2'b00: begin
               chk(req_kind_o == e_kind, "R5 kind", 64'(req_kind_o), 64'(e_kind));
               chk(req_chan_o == e_chan, "R5 chan", 64'(req_chan_o), 64'(e_chan));
               chk(req_word_o == e_word, "R5 word", req_word_o, e_word);
            end
            2'b01: begin
               chk(req_kind_o == e_kind, "R6 kind", 64'(req_kind_o), 64'(e_kind));
               chk(req_chan_o == e_chan, "R6 R8 chan", 64'(req_chan_o), 64'(e_chan));
               chk(req_word_o == 0, "R10 word", req_word_o, 64'd0);
            end
            default: begin
               chk(req_kind_o == e_kind, "R7 kind", 64'(req_kind_o), 64'(e_kind));
               chk(req_chan_o == 2'd2, "R7 chan", 64'(req_chan_o), 64'd2);
               chk(req_word_o == 0, "R10 word", req_word_o, 64'd0);
            end
         endcase
      end
      rel_req_i  = rel;
      xfer_req_i = xfer;
      data_i     = data;
      cap  = av_h[2];
      busy = |av_h;
      nav  = rel & ~xfer & ~busy;
      e_valid = xfer;
      if (cap) begin
         e_kind = 2'b00; e_chan = data[1:0]; e_word = data;
      end else if (rel) begin
         e_kind = 2'b10; e_chan = 2'd2; e_word = 0;
      end else begin
         e_kind = 2'b01; e_chan = m_last; e_word = 0;
      end
      if (xfer && (cap || rel)) m_last = e_chan;
      av_h    = {av_h[2:0], nav};
      e_avail = nav;
      e_oe    = !(av_h[1] | av_h[2] | av_h[3]);
   endtask

   // One bus loan followed by a normal request on channel c
   task automatic loan(input logic [1:0] c, input logic [61:0] tag, input logic rel_too);
      tick(1, 0, 64'hDEAD);           // sampled here
      tick(0, 0, 64'hBEEF);           // bus-available cycle
      tick(0, 0, 64'h1234);           // A+1
      tick(rel_too, 1, {tag, c});     // A+2 capture slot
      tick(0, 0, 0);                  // A+3
   endtask

   initial begin
      #(MAX_CYCLES * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, then a repeat reports channel 0
      @(posedge clk); #1;
      checks++;
      if (!(data_oe_o && !bus_avail_o && !req_valid_o)) begin
         errors++;
         $display("FAIL R1 reset state actual=%b%b%b expected=100",
                  data_oe_o, bus_avail_o, req_valid_o);
      end
      tick(0, 1, 64'hFFFF_FFFF_FFFF_FFFF);   // R1 repeat with last=0, R10 data ignored
      tick(0, 0, 0);
      // R5 R6 R8: every channel with several words
      for (int c = 0; c < 4; c++) begin
         for (int p = 0; p < 3; p++) begin
            loan(2'(c), 62'(64'h0F0F_1234_5678_9ABC >> (p * 7)) ^ 62'(c), p == 2);
            tick(0, 1, 64'h5555);           // repeat must report c
            tick(0, 0, 0);
         end
      end
      // R7 R8: direct then repeat reports 2, no loan started
      tick(1, 1, 64'h3);
      tick(0, 0, 0);
      tick(0, 1, 64'h1);
      tick(0, 0, 0);
      // R10: strobe in A+1 is a repeat, data ignored
      tick(1, 0, 0);
      tick(0, 0, 0);
      tick(0, 1, 64'hABCD_0001);
      tick(0, 0, 0);
      tick(0, 0, 0);
      // R4: release request held high
      for (int i = 0; i < 16; i++) tick(1, 0, 0);
      tick(0, 0, 0);
      // Sweep with pseudo-random stimulus
      lfsr = 32'hACE1_2345;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         tick(lfsr[3:2] == 2'b00, lfsr[7:6] == 2'b01, {lfsr, ~lfsr});
      end
      tick(0, 0, 0);
      tick(0, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule